// File: doc/BRIEF.md
# Pointer Register File with Shared Step Unit

This block holds sixteen 16-bit general registers that serve as pointers and counters for a small processor. A single step unit, placed outside the register array and outside the data ALU, reads the register picked by the select input. It adds or subtracts one and writes the result back into the same register. The register array itself contains no counters. One read-modify-write can happen in each clock cycle.

The operation code chooses what happens at the next rising edge:

- hold: nothing is written.
- load: the data input is written into the selected register.
- increment: the selected register gains one.
- decrement: the selected register loses one.
- fetch-and-increment: the selected register's present value is used as a memory address during the cycle, and the register steps up by one at the edge.

The read output always shows the selected register combinationally. It therefore doubles as the address output during a fetch.

There is no multi-cycle sequencing. The decoder maps each operation code straight to a control word in the same cycle, and each operation takes effect at the very next rising edge.

Top module: `rfi_ptr_file`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to 0x0000 at the next rising edge.
- R2: With operation code 0 (hold), no register changes, and the read output equals the selected register combinationally.
- R3: With operation code 1 (load), the selected register holds the 16-bit data input after the rising edge.
- R4: With operation code 2 (increment), the selected register holds its previous value plus one after the rising edge.
- R5: With operation code 3 (decrement), the selected register holds its previous value minus one after the rising edge.
- R6: With operation code 4 (fetch-and-increment), the read output shows the register's value before the update during the cycle, and the register holds that value plus one after the edge.
- R7: Stepping wraps without flags. Increment takes 0xFFFF to 0x0000, and decrement takes 0x0000 to 0xFFFF.
- R8: At most one register, the selected one, is written per cycle. All other registers keep their values.
- R9: Operation codes 5, 6 and 7 behave as hold. The data input is ignored and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 4 | Register select |
| op | input | 3 | Operation code: 0 hold, 1 load, 2 increment, 3 decrement, 4 fetch-and-increment, 5 to 7 hold |
| wdata | input | 16 | Load data |
| rdata | output | 16 | Selected register value, also the fetch address |

## Verification
The hardest situations to reach from the ports are the two wrap points and the claim that nothing outside the selected register is touched. A register can only reach 0xFFFF through a load, or through a decrement from zero.

The stimulus table therefore loads 0xFFFF and then increments it, decrements a register that still holds its reset value of zero, and then reads both back. It also revisits a register that was never written, and a register that received ignored operation codes carrying nonzero data. This shows through the read port that no stray write landed there.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HOLD  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_FETCH = 3'd4
    } rfi_op_e;

    typedef struct packed {
        logic wr_en;
        logic use_step;
        logic step_down;
    } rfi_ctl_t;
endpackage

// File: rtl/rfi_op_decode.sv
module rfi_op_decode
    import rfi_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output rfi_ctl_t        ctl
);
    always_comb begin
        ctl = '0;
        unique case (op_code)
            OP_LOAD:  ctl = '{wr_en: 1'b1, use_step: 1'b0, step_down: 1'b0};
            OP_INC:   ctl = '{wr_en: 1'b1, use_step: 1'b1, step_down: 1'b0};
            OP_DEC:   ctl = '{wr_en: 1'b1, use_step: 1'b1, step_down: 1'b1};
            OP_FETCH: ctl = '{wr_en: 1'b1, use_step: 1'b1, step_down: 1'b0};
            default:  ctl = '0;  // hold and unused codes (R9)
        endcase
    end
endmodule

// File: rtl/rfi_step_unit.sv
module rfi_step_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] src,
    input  logic         down,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        res = down ? (src - ONE) : (src + ONE);
    end

    always_comb begin
        // R7
        if (!down && src == '1) step_wrap_up_chk: assert (res == '0);
        // R7
        if (down && src == '0) step_wrap_down_chk: assert (res == '1);
    end
endmodule

// File: rtl/rfi_reg_array.sv
module rfi_reg_array #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdat,
    input  logic [$clog2(N)-1:0] raddr,
    output logic [W-1:0]         rdat,
    output logic [N-1:0][W-1:0]  q_all
);
    localparam int AW = $clog2(N);

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q_all[i] <= '0;
            else if (we && waddr == AW'(i))
                q_all[i] <= wdat;
        end

        // R8
        untouched_reg_chk: assert property (@(posedge clk) disable iff (rst)
            !(we && waddr == AW'(i)) |=> q_all[i] == $past(q_all[i]));
    end

    assign rdat = q_all[raddr];
endmodule

// File: rtl/rfi_ptr_file.sv
module rfi_ptr_file
    import rfi_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [$clog2(N)-1:0] sel,
    input  logic [OP_W-1:0]      op,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         rdata
);
    localparam logic [W-1:0] ONE = W'(1);

    rfi_ctl_t            ctl;
    logic [W-1:0]        step_res;
    logic [W-1:0]        wr_val;
    logic [N-1:0][W-1:0] q_all;

    rfi_op_decode u_dec (
        .op_code (op),
        .ctl     (ctl)
    );

    rfi_step_unit #(.W(W)) u_step (
        .src  (rdata),
        .down (ctl.step_down),
        .res  (step_res)
    );

    always_comb begin
        wr_val = ctl.use_step ? step_res : wdata;
    end

    rfi_reg_array #(.N(N), .W(W)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.wr_en),
        .waddr (sel),
        .wdat  (wr_val),
        .raddr (sel),
        .rdat  (rdata),
        .q_all (q_all)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> q_all == '0);

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> q_all == $past(q_all));

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> q_all[$past(sel)] == $past(wdata));

    // R4
    inc_value_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_INC |=> q_all[$past(sel)] == $past(rdata) + ONE);

    // R5
    dec_value_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_DEC |=> q_all[$past(sel)] == $past(rdata) - ONE);

    // R6
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_FETCH |=> q_all[$past(sel)] == $past(rdata) + ONE);

    // R9
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        op > OP_FETCH |=> q_all == $past(q_all));
endmodule

// File: tb/sim_rfi_ptr_file.sv
module sim_rfi_ptr_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sel = '0;
    logic [2:0]  op  = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    rfi_ptr_file u0 (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .op    (op),
        .wdata (wdata),
        .rdata (rdata)
    );

    // row: {req tag number(4), op(3), sel(4), wdata(16), expected rdata before edge(16)}
    localparam int ROWS = 17;
    localparam logic [42:0] VEC [ROWS] = '{
        {4'd3, 3'd1, 4'd3,  16'h1234, 16'h0000},  // R3 load
        {4'd4, 3'd2, 4'd3,  16'h0000, 16'h1234},  // R4 inc
        {4'd6, 3'd4, 4'd3,  16'h0000, 16'h1235},  // R6 fetch shows old
        {4'd6, 3'd0, 4'd3,  16'h0000, 16'h1236},  // R6 stepped after fetch
        {4'd5, 3'd3, 4'd3,  16'h0000, 16'h1236},  // R5 dec
        {4'd3, 3'd1, 4'd15, 16'hFFFF, 16'h0000},  // R3 load top
        {4'd7, 3'd2, 4'd15, 16'h0000, 16'hFFFF},  // R7 inc at max
        {4'd7, 3'd0, 4'd15, 16'h0000, 16'h0000},  // R7 wrapped to zero
        {4'd7, 3'd3, 4'd0,  16'h0000, 16'h0000},  // R7 dec at zero
        {4'd7, 3'd0, 4'd0,  16'h0000, 16'hFFFF},  // R7 wrapped to max
        {4'd9, 3'd5, 4'd3,  16'hAAAA, 16'h1235},  // R9 code 5
        {4'd9, 3'd6, 4'd3,  16'h5555, 16'h1235},  // R9 code 6
        {4'd9, 3'd7, 4'd15, 16'h5555, 16'h0000},  // R9 code 7
        {4'd6, 3'd4, 4'd15, 16'h0000, 16'h0000},  // R6 fetch
        {4'd6, 3'd4, 4'd15, 16'h0000, 16'h0001},  // R6 fetch again
        {4'd2, 3'd0, 4'd15, 16'h0000, 16'h0002},  // R2 hold read
        {4'd8, 3'd0, 4'd7,  16'h0000, 16'h0000}   // R8 untouched register
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [3:0] s, input logic [15:0] d);
        @(negedge clk);
        op = o;
        sel = s;
        wdata = d;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register reads zero after reset
        for (int i = 0; i < 16; i++) begin
            step(3'd0, 4'(i), 16'h0);
            chk($sformatf("R1 reset reg %0d", i), rdata, 16'h0000);
        end

        for (int r = 0; r < ROWS; r++) begin
            step(VEC[r][38:36], VEC[r][35:32], VEC[r][31:16]);
            chk($sformatf("R%0d row %0d", VEC[r][42:39], r), rdata, VEC[r][15:0]);
        end

        // R8: step one register, neighbour keeps its value
        step(3'd1, 4'd5, 16'h0BEE);
        step(3'd2, 4'd6, 16'hFFFF);
        step(3'd3, 4'd4, 16'h1111);
        step(3'd0, 4'd5, 16'h0);
        chk("R8 neighbour 5", rdata, 16'h0BEE);
        step(3'd0, 4'd6, 16'h0);
        chk("R8 stepped 6", rdata, 16'h0001);
        step(3'd0, 4'd4, 16'h0);
        chk("R8 stepped 4", rdata, 16'hFFFF);

        // R2: combinational read follows select within the cycle
        step(3'd0, 4'd3, 16'h0);
        chk("R2 comb read 3", rdata, 16'h1235);
        sel = 4'd5;
        #1;
        chk("R2 comb read 5", rdata, 16'h0BEE);

        // R1: reset clears written registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step(3'd0, 4'd3, 16'h0);
        chk("R1 clear 3", rdata, 16'h0000);
        step(3'd0, 4'd0, 16'h0);
        chk("R1 clear 0", rdata, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule